// File: doc/BRIEF.md
# Two-Level Page Translation Walker

This block turns a 32-bit linear address into a physical address by walking a two-level tree of page entries held in memory. A small direct-mapped translation cache sits in front of the walker. A hit answers without any memory traffic. A miss reads the directory entry and then the table entry over a word-wide memory port that uses a valid/ready handshake. On the way down the walker sets the accessed bit, and for a write the dirty bit, and writes each changed entry back to the address it came from. The writable and user bits of the two levels are combined into one merged entry, which then goes into the cache.

Each request carries an address, a write flag, the current privilege level and a virtual-8086 flag. Three configuration inputs go with it: a paging enable, a write-protect enable and the frame number of the root directory. The block accepts one request at a time. It answers with a single-cycle response that carries either a physical address or a page fault with a 3-bit error code. When paging is off, the address passes straight through.

Top module: `xw_xlat_top`

## Requirements
- R1: When pg_en is 0 at acceptance, the response carries resp_paddr equal to req_addr, resp_fault 0 and resp_err 0, and no memory access is made.
- R2: Entry layout: bit 0 present, bit 1 writable, bit 2 user, bit 5 accessed, bit 6 dirty, bits 31:12 frame. The directory entry is read at {pt_root_frame, addr[31:22], 2'b00}. The table entry is read at {directory frame, addr[21:12], 2'b00}. The physical address is {table frame, addr[11:0]}.
- R3: If the directory entry or the table entry is not present, the walk stops at once and yields an all-zero merged entry, which faults with error code 0. A missing directory entry costs exactly one memory read.
- R4: An entry whose accessed bit is clear is written back, with bit 5 set, to the address it was read from, before the walk moves on.
- R5: A write request sets the dirty bit of the table entry. The table entry is written back whenever the accessed or dirty update changes it, and not otherwise.
- R6: In the merged entry, the writable bit is the AND of the directory and table writable bits, and the user bit is the AND of the two user bits.
- R7: A fault is raised when the merged entry is not present, or when its user bit is 0 and the effective privilege is above 0, or when the request is a write, wp_en is 1 and the merged writable bit is 0. The effective privilege is 3 when req_v86 is 1, and req_cpl otherwise.
- R8: With paging on, resp_err equals merged bits {user, writable, present}.
- R9: The cache has 16 direct-mapped slots, indexed by addr[15:12] and tagged by addr[31:16]. A hit answers from the stored merged entry with no memory access. Only a walk that finds both levels present fills a slot.
- R10: A cycle with flush high invalidates every cache slot.
- R11: mem_valid, mem_addr, mem_write and mem_wdata hold steady until mem_ready. req_ready is low from acceptance until the response. resp_valid is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all cache slots |
| pg_en | input | 1 | Paging enable |
| wp_en | input | 1 | Write-protect enable for read-only pages |
| pt_root_frame | input | 20 | Frame number of the root directory |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_addr | input | 32 | Linear address |
| req_write | input | 1 | Request is a write |
| req_cpl | input | 2 | Current privilege level |
| req_v86 | input | 1 | Virtual-8086 flag, forces privilege 3 |
| resp_valid | output | 1 | Response pulse |
| resp_paddr | output | 32 | Physical address |
| resp_fault | output | 1 | Page fault |
| resp_err | output | 3 | Fault error code |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | Access is a write-back |
| mem_addr | output | 32 | Word address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |

## Verification
A vector table drives reads and writes through a prepared set of page entries. Each vector flushes the cache first, so the number of memory accesses it costs shows which write-backs took place. The entries are chosen so that the tests can tell apart: entries that are already accessed or dirty from ones that are not, a missing entry at each level, a directory that denies writes or user access while its table allows them, privilege 0 against privilege 3, the virtual-8086 override, and write-protect on and off. Directed tests then cover four more cases. A repeated address must cost no access. An address with the same cache index but a different tag must walk. A faulting walk must not fill the cache, and a flush must force a walk again. Finally, they cover pass-through mode and a memory that stalls.

// File: rtl/xw_pkg.sv
package xw_pkg;

  localparam int XW_AW    = 32;
  localparam int XW_OFS_W = 12;
  localparam int XW_VPN_W = XW_AW - XW_OFS_W;
  localparam int XW_LVL_W = XW_VPN_W / 2;

  localparam int B_PRES = 0;
  localparam int B_WR   = 1;
  localparam int B_USER = 2;
  localparam int B_ACC  = 5;
  localparam int B_DIRTY = 6;

  typedef struct packed {
    logic [XW_VPN_W-1:0] frame;
    logic                user;
    logic                wr;
    logic                present;
  } xlat_ent_t;

  function automatic logic [XW_AW-1:0] dir_slot_addr(
    input logic [XW_VPN_W-1:0] root, input logic [XW_AW-1:0] va);
    return {root, va[XW_AW-1 -: XW_LVL_W], 2'b00};
  endfunction

  function automatic logic [XW_AW-1:0] tbl_slot_addr(
    input logic [XW_AW-1:0] dir_ent, input logic [XW_AW-1:0] va);
    return {dir_ent[XW_AW-1:XW_OFS_W], va[XW_OFS_W +: XW_LVL_W], 2'b00};
  endfunction

  function automatic xlat_ent_t merge_levels(
    input logic [XW_AW-1:0] dir_ent, input logic [XW_AW-1:0] tbl_ent);
    xlat_ent_t m;
    m.frame   = tbl_ent[XW_AW-1:XW_OFS_W];
    m.present = tbl_ent[B_PRES];
    m.wr      = tbl_ent[B_WR] & dir_ent[B_WR];
    m.user    = tbl_ent[B_USER] & dir_ent[B_USER];
    return m;
  endfunction

  function automatic logic [1:0] eff_priv(input logic [1:0] cpl, input logic v86);
    return v86 ? 2'd3 : cpl;
  endfunction

  function automatic logic page_fault(
    input xlat_ent_t e, input logic is_wr, input logic [1:0] priv, input logic wp);
    return !e.present || (!e.user && (priv != 2'd0)) || (is_wr && wp && !e.wr);
  endfunction

endpackage

// File: rtl/xw_cache.sv
module xw_cache
  import xw_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [XW_VPN_W-1:0] lk_vpn,
  output logic                lk_hit,
  output xlat_ent_t           lk_ent,
  input  logic                fill_en,
  input  logic [XW_VPN_W-1:0] fill_vpn,
  input  xlat_ent_t           fill_ent
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_W = XW_VPN_W - IDX_W;

  logic             vld   [DEPTH];
  logic [TAG_W-1:0] tag_r [DEPTH];
  xlat_ent_t        ent_r [DEPTH];

  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag;

  assign lk_idx   = lk_vpn[IDX_W-1:0];
  assign lk_tag   = lk_vpn[XW_VPN_W-1:IDX_W];
  assign fill_idx = fill_vpn[IDX_W-1:0];
  assign fill_tag = fill_vpn[XW_VPN_W-1:IDX_W];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[s]   <= 1'b0;
        tag_r[s] <= '0;
        ent_r[s] <= '0;
      end else if (flush) begin
        vld[s] <= 1'b0;
      end else if (fill_en && (fill_idx == IDX_W'(s))) begin
        vld[s]   <= 1'b1;
        tag_r[s] <= fill_tag;
        ent_r[s] <= fill_ent;
      end
    end
  end

  assign lk_hit = vld[lk_idx] && (tag_r[lk_idx] == lk_tag);
  assign lk_ent = ent_r[lk_idx];

endmodule

// File: rtl/xw_walker.sv
module xw_walker
  import xw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [XW_AW-1:0]    va,
  input  logic                is_wr,
  input  logic [XW_VPN_W-1:0] root,
  output logic                mem_valid,
  output logic                mem_write,
  output logic [XW_AW-1:0]    mem_addr,
  output logic [XW_AW-1:0]    mem_wdata,
  input  logic                mem_ready,
  input  logic [XW_AW-1:0]    mem_rdata,
  output logic                done,
  output logic                done_fill,
  output xlat_ent_t           done_ent
);
  typedef enum logic [2:0] {
    W_IDLE, W_RD_DIR, W_WB_DIR, W_RD_TBL, W_WB_TBL, W_DONE
  } wst_e;

  wst_e                st;
  logic [XW_AW-1:0]    va_q, dir_q, tbl_q;
  logic                wr_q;
  logic [XW_VPN_W-1:0] root_q;
  logic [XW_AW-1:0]    tbl_upd;

  assign tbl_upd = mem_rdata | (XW_AW'(1) << B_ACC) | (wr_q ? (XW_AW'(1) << B_DIRTY) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= W_IDLE;
      va_q      <= '0;
      wr_q      <= 1'b0;
      root_q    <= '0;
      dir_q     <= '0;
      tbl_q     <= '0;
      done_ent  <= '0;
      done_fill <= 1'b0;
    end else begin
      case (st)
        W_IDLE: if (start) begin
          va_q   <= va;
          wr_q   <= is_wr;
          root_q <= root;
          st     <= W_RD_DIR;
        end
        W_RD_DIR: if (mem_ready) begin
          dir_q <= mem_rdata | (XW_AW'(1) << B_ACC);
          if (!mem_rdata[B_PRES]) begin
            done_ent  <= '0;
            done_fill <= 1'b0;
            st        <= W_DONE;
          end else if (!mem_rdata[B_ACC]) begin
            st <= W_WB_DIR;
          end else begin
            st <= W_RD_TBL;
          end
        end
        W_WB_DIR: if (mem_ready) st <= W_RD_TBL;
        W_RD_TBL: if (mem_ready) begin
          tbl_q <= tbl_upd;
          if (!mem_rdata[B_PRES]) begin
            done_ent  <= '0;
            done_fill <= 1'b0;
            st        <= W_DONE;
          end else if (tbl_upd != mem_rdata) begin
            st <= W_WB_TBL;
          end else begin
            done_ent  <= merge_levels(dir_q, tbl_upd);
            done_fill <= 1'b1;
            st        <= W_DONE;
          end
        end
        W_WB_TBL: if (mem_ready) begin
          done_ent  <= merge_levels(dir_q, tbl_q);
          done_fill <= 1'b1;
          st        <= W_DONE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = tbl_slot_addr(dir_q, va_q);
    mem_wdata = tbl_q;
    case (st)
      W_RD_DIR: begin mem_valid = 1'b1; mem_addr = dir_slot_addr(root_q, va_q); end
      W_WB_DIR: begin
        mem_valid = 1'b1; mem_write = 1'b1;
        mem_addr  = dir_slot_addr(root_q, va_q);
        mem_wdata = dir_q;
      end
      W_RD_TBL: mem_valid = 1'b1;
      W_WB_TBL: begin mem_valid = 1'b1; mem_write = 1'b1; end
      default: ;
    endcase
  end

  assign done = (st == W_DONE);

endmodule

// File: rtl/xw_perm.sv
module xw_perm
  import xw_pkg::*;
(
  input  xlat_ent_t        ent,
  input  logic [XW_AW-1:0] va,
  input  logic             is_wr,
  input  logic [1:0]       cpl,
  input  logic             v86,
  input  logic             wp,
  input  logic             pass,
  output logic [XW_AW-1:0] paddr,
  output logic             fault,
  output logic [2:0]       err
);
  always_comb begin
    if (pass) begin
      paddr = va;
      fault = 1'b0;
      err   = 3'd0;
    end else begin
      paddr = {ent.frame, va[XW_OFS_W-1:0]};
      fault = page_fault(ent, is_wr, eff_priv(cpl, v86), wp);
      err   = {ent.user, ent.wr, ent.present};
    end
  end
endmodule

// File: rtl/xw_xlat_top.sv
module xw_xlat_top
  import xw_pkg::*;
#(
  parameter int CACHE_DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                pg_en,
  input  logic                wp_en,
  input  logic [XW_VPN_W-1:0] pt_root_frame,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [XW_AW-1:0]    req_addr,
  input  logic                req_write,
  input  logic [1:0]          req_cpl,
  input  logic                req_v86,
  output logic                resp_valid,
  output logic [XW_AW-1:0]    resp_paddr,
  output logic                resp_fault,
  output logic [2:0]          resp_err,
  output logic                mem_valid,
  output logic                mem_write,
  output logic [XW_AW-1:0]    mem_addr,
  output logic [XW_AW-1:0]    mem_wdata,
  input  logic                mem_ready,
  input  logic [XW_AW-1:0]    mem_rdata
);
  typedef enum logic [1:0] {T_IDLE, T_WALK, T_RESP} tst_e;

  tst_e             st;
  logic [XW_AW-1:0] va_q;
  logic             wr_q, v86_q, wp_q, pass_q;
  logic [1:0]       cpl_q;
  xlat_ent_t        ent_q;

  logic      lk_hit, walk_done, walk_fill;
  xlat_ent_t lk_ent, walk_ent;

  logic evt_accept, evt_hit, evt_miss, evt_fill;

  assign req_ready  = (st == T_IDLE);
  assign evt_accept = req_valid && req_ready;
  assign evt_hit    = evt_accept && pg_en && lk_hit;
  assign evt_miss   = evt_accept && pg_en && !lk_hit;
  assign evt_fill   = walk_done && walk_fill;

  xw_cache #(.DEPTH(CACHE_DEPTH)) u_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_vpn(req_addr[XW_AW-1:XW_OFS_W]), .lk_hit(lk_hit), .lk_ent(lk_ent),
    .fill_en(evt_fill), .fill_vpn(va_q[XW_AW-1:XW_OFS_W]), .fill_ent(walk_ent)
  );

  xw_walker u_walk (
    .clk(clk), .rst_n(rst_n), .start(evt_miss), .va(req_addr), .is_wr(req_write),
    .root(pt_root_frame), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .done(walk_done), .done_fill(walk_fill), .done_ent(walk_ent)
  );

  xw_perm u_perm (
    .ent(ent_q), .va(va_q), .is_wr(wr_q), .cpl(cpl_q), .v86(v86_q), .wp(wp_q),
    .pass(pass_q), .paddr(resp_paddr), .fault(resp_fault), .err(resp_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= T_IDLE;
      va_q   <= '0;
      wr_q   <= 1'b0;
      cpl_q  <= 2'd0;
      v86_q  <= 1'b0;
      wp_q   <= 1'b0;
      pass_q <= 1'b0;
      ent_q  <= '0;
    end else begin
      case (st)
        T_IDLE: if (evt_accept) begin
          va_q   <= req_addr;
          wr_q   <= req_write;
          cpl_q  <= req_cpl;
          v86_q  <= req_v86;
          wp_q   <= wp_en;
          pass_q <= !pg_en;
          if (evt_hit) ent_q <= lk_ent;
          st <= evt_miss ? T_WALK : T_RESP;
        end
        T_WALK: if (walk_done) begin
          ent_q <= walk_ent;
          st    <= T_RESP;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assign resp_valid = (st == T_RESP);

endmodule

// File: rtl/xw_xlat_sva.sv
module xw_xlat_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        pg_en,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        resp_valid,
  input logic [31:0] resp_paddr,
  input logic        resp_fault,
  input logic [2:0]  resp_err,
  input logic        mem_valid,
  input logic        mem_write,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ready,
  input logic        evt_accept,
  input logic        evt_hit,
  input logic        pass_q
);
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept && !pg_en |=> resp_valid && !resp_fault && (resp_paddr == $past(req_addr))); // R1

  AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !pass_q && !resp_err[0] |-> resp_fault); // R7

  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> mem_wdata[5]); // R4

  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> !mem_valid); // R9

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)
      && $stable(mem_wdata)); // R11

  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready); // R11

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R11
endmodule

bind xw_xlat_top xw_xlat_sva u_sva (
  .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .req_ready(req_ready), .req_addr(req_addr),
  .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
  .resp_err(resp_err), .mem_valid(mem_valid), .mem_write(mem_write),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .evt_accept(evt_accept), .evt_hit(evt_hit), .pass_q(pass_q)
);

// File: tb/xw_xlat_top_test.sv
`timescale 1ns/1ps
module xw_xlat_top_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        flush = 1'b0, pg_en = 1'b1, wp_en = 1'b0;
  logic [19:0] pt_root_frame = 20'h00010;
  logic        req_valid = 1'b0, req_write = 1'b0, req_v86 = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_cpl = 2'd0;
  logic        req_ready, resp_valid, resp_fault, mem_valid, mem_write;
  logic [31:0] resp_paddr, mem_addr, mem_wdata;
  logic [2:0]  resp_err;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  xw_xlat_top uut (.*);

  logic [31:0] mem [int unsigned];
  int n_chk = 0, n_err = 0, acc_cnt = 0, stall = 0, wait_cnt = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  initial forever begin
    @(negedge clk);
    if (mem_ready) begin mem_ready = 1'b0; wait_cnt = stall; end
    else if (mem_valid) begin
      if (wait_cnt == 0) begin mem_ready = 1'b1; mem_rdata = rd(mem_addr); end
      else wait_cnt--;
    end
  end

  always @(posedge clk) if (mem_valid && mem_ready) begin
    acc_cnt++;
    if (mem_write) mem[mem_addr] = mem_wdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  logic        r_fault;
  logic [31:0] r_pa;
  logic [2:0]  r_err;

  task automatic xlat(input logic [31:0] a, input logic w, input logic [1:0] c,
                      input logic v, input logic wp);
    int t = 0;
    acc_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_cpl = c; req_v86 = v; wp_en = wp;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid && t < 1000) begin @(negedge clk); t++; end
    if (t >= 1000) begin
      n_chk++; n_err++;
      $display("FAIL R11 response timeout actual=none expected=resp_valid");
    end
    r_fault = resp_fault; r_pa = resp_paddr; r_err = resp_err;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] va; logic wr; logic [1:0] cpl; logic v86; logic wp;
    logic flt; logic [31:0] pa; logic [2:0] err; logic [3:0] acc; logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{32'h0000_0ABC,1'b0,2'd0,1'b0,1'b0, 1'b0,32'h0010_0ABC,3'd7,4'd2,4'd2},  // R2 plain walk
    '{32'h0000_1010,1'b1,2'd3,1'b0,1'b1, 1'b0,32'h0010_1010,3'd7,4'd3,4'd5},  // R5 A and D set, one write-back
    '{32'h0000_2000,1'b0,2'd0,1'b0,1'b0, 1'b1,32'h0,        3'd0,4'd2,4'd3},  // R3 table absent
    '{32'h0000_3444,1'b1,2'd0,1'b0,1'b1, 1'b1,32'h0,        3'd5,4'd3,4'd7},  // R7 write-protect fault
    '{32'h0000_3444,1'b1,2'd0,1'b0,1'b0, 1'b0,32'h0010_3444,3'd5,4'd2,4'd5},  // R5 already dirty, no write-back
    '{32'h0040_0123,1'b0,2'd3,1'b0,1'b0, 1'b0,32'h0020_0123,3'd5,4'd3,4'd4},  // R4 directory write-back
    '{32'h0040_0123,1'b1,2'd3,1'b0,1'b1, 1'b1,32'h0,        3'd5,4'd3,4'd6},  // R6 directory denies write
    '{32'h0080_0000,1'b0,2'd0,1'b0,1'b0, 1'b1,32'h0,        3'd0,4'd1,4'd3},  // R3 directory absent
    '{32'h00C0_0010,1'b0,2'd3,1'b0,1'b0, 1'b1,32'h0,        3'd3,4'd2,4'd7},  // R7 supervisor page, cpl 3
    '{32'h00C0_0010,1'b0,2'd0,1'b1,1'b0, 1'b1,32'h0,        3'd3,4'd2,4'd7},  // R7 v86 forces privilege 3
    '{32'h00C0_0010,1'b0,2'd0,1'b0,1'b0, 1'b0,32'h0030_0010,3'd3,4'd2,4'd8},  // R8 supervisor ok
    '{32'h00C0_0020,1'b1,2'd0,1'b0,1'b1, 1'b0,32'h0030_0020,3'd3,4'd2,4'd6},  // R6 both writable
    '{32'h0000_0FFF,1'b1,2'd2,1'b0,1'b1, 1'b0,32'h0010_0FFF,3'd7,4'd2,4'd8}   // R8 page edge
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    mem[32'h0001_0000] = 32'h0002_0027;
    mem[32'h0001_0004] = 32'h0003_0005;
    mem[32'h0001_000C] = 32'h0005_0023;
    mem[32'h0002_0000] = 32'h0010_0067;
    mem[32'h0002_0004] = 32'h0010_1007;
    mem[32'h0002_000C] = 32'h0010_3025;
    mem[32'h0003_0000] = 32'h0020_0027;
    mem[32'h0005_0000] = 32'h0030_0067;

    repeat (3) @(negedge clk);
    chk("R11 reset resp_valid", {31'b0, resp_valid}, 32'h0);
    chk("R11 reset mem_valid", {31'b0, mem_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle req_ready", {31'b0, req_ready}, 32'h1);

    foreach (VECS[i]) begin
      do_flush();
      xlat(VECS[i].va, VECS[i].wr, VECS[i].cpl, VECS[i].v86, VECS[i].wp);
      n_chk++;
      if (r_fault !== VECS[i].flt) begin n_err++;
        $display("FAIL R%0d vec %0d fault actual=%b expected=%b", VECS[i].req, i, r_fault, VECS[i].flt); end
      n_chk++;
      if (r_err !== VECS[i].err) begin n_err++;
        $display("FAIL R%0d vec %0d err actual=%h expected=%h", VECS[i].req, i, r_err, VECS[i].err); end
      n_chk++;
      if (acc_cnt != int'(VECS[i].acc)) begin n_err++;
        $display("FAIL R%0d vec %0d accesses actual=%0d expected=%0d", VECS[i].req, i, acc_cnt, VECS[i].acc); end
      if (!VECS[i].flt) begin
        n_chk++;
        if (r_pa !== VECS[i].pa) begin n_err++;
          $display("FAIL R%0d vec %0d paddr actual=%h expected=%h", VECS[i].req, i, r_pa, VECS[i].pa); end
      end
    end

    chk("R4 directory accessed written back", rd(32'h0001_0004), 32'h0003_0025);
    chk("R5 table dirty written back", rd(32'h0002_0004), 32'h0010_1067);
    chk("R5 dirty set on faulting write", rd(32'h0002_000C), 32'h0010_3065);
    chk("R5 dirty under read-only directory", rd(32'h0003_0000), 32'h0020_0067);

    // R1 pass-through
    pg_en = 1'b0;
    xlat(32'hDEAD_BEEF, 1'b1, 2'd3, 1'b1, 1'b1);
    chk("R1 paddr", r_pa, 32'hDEAD_BEEF);
    chk("R1 fault", {31'b0, r_fault}, 32'h0);
    chk("R1 err", {29'b0, r_err}, 32'h0);
    chk("R1 no access", acc_cnt, 0);
    pg_en = 1'b1;

    // R9 hit after fill
    do_flush();
    xlat(32'h0000_0123, 1'b0, 2'd0, 1'b0, 1'b0);
    chk("R9 first walk accesses", acc_cnt, 2);
    xlat(32'h0000_0123, 1'b0, 2'd0, 1'b0, 1'b0);
    chk("R9 hit no access", acc_cnt, 0);
    chk("R9 hit paddr", r_pa, 32'h0010_0123);
    chk("R9 hit err", {29'b0, r_err}, 32'h7);
    // R9 same index, different tag: walks, absent entry not cached
    xlat(32'h0001_0000, 1'b0, 2'd0, 1'b0, 1'b0);
    chk("R9 tag mismatch walks", acc_cnt, 2);
    chk("R3 absent entry faults", {31'b0, r_fault}, 32'h1);
    xlat(32'h0000_0456, 1'b0, 2'd0, 1'b0, 1'b0);
    chk("R9 faulting walk did not fill", acc_cnt, 0);
    chk("R9 old slot paddr", r_pa, 32'h0010_0456);

    // R10 flush
    do_flush();
    xlat(32'h0000_0456, 1'b0, 2'd0, 1'b0, 1'b0);
    chk("R10 flush forces walk", acc_cnt, 2);

    // R11 stalled memory and busy indication
    do_flush();
    stall = 3; wait_cnt = 3;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0040_0777; req_write = 1'b0; req_cpl = 2'd0; req_v86 = 1'b0;
    acc_cnt = 0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 req_ready low while walking", {31'b0, req_ready}, 32'h0);
    begin
      int t = 0;
      while (!resp_valid && t < 1000) begin @(negedge clk); t++; end
    end
    chk("R11 stalled walk paddr", resp_paddr, 32'h0020_0777);
    chk("R11 stalled walk accesses", acc_cnt, 2);
    @(negedge clk);
    chk("R11 response single cycle", {31'b0, resp_valid}, 32'h0);
    stall = 0;

    summary();
  end
endmodule